// File: doc/BRIEF.md
# Trap Vector Target Unit

This unit keeps the machine trap-vector register and the exception-PC register of a processor core, and works out where instruction fetch goes next when a trap is taken or a machine-mode return runs. The trap-vector register holds a base address aligned to the size of a jump table, plus a mode bit. In direct mode every trap goes to the base address. In vectored mode a synchronous exception still goes to the base address, which is table entry zero, while an interrupt goes to its own entry, four bytes per cause.

The core's CSR logic drives write and read strobes, a register select and write data. The trap logic raises a one-cycle strobe with an interrupt flag, a cause number and the PC to save. One cycle after a trap or a return, the unit raises a redirect-valid flag together with the target PC. Software can find out whether vectored mode is supported by writing a base with the mode bit set and then reading the register back.

Top module: `trap_vector_unit`

## Requirements
- R1: After reset the vector base is zero, the mode is direct, the saved PC is zero, and `redirectValid` is low.
- R2: A write with `csrSel`=0 stores data bits [XLEN-1:ALIGN_BITS] as the base. While `csrRdEn` is high, `csrRdData` shows in the same cycle base | mode, with bits [ALIGN_BITS-1:1] reading zero. While `csrRdEn` is low, `csrRdData` is zero.
- R3: Bits [1:0] of the vector write data choose the mode: 0 gives direct and 1 gives vectored. The values 2 and 3 leave the mode as it was, but the base is still updated.
- R4: A taken exception (`trapIsIrq`=0) redirects to the base address in both modes.
- R5: A taken interrupt in vectored mode redirects to base + 4 × cause. Cause 1 lands on base+4 and cause 15 on base+60.
- R6: A taken interrupt in direct mode redirects to the base address.
- R7: A trap stores `trapPc` with bits [1:0] cleared as the saved PC. A CSR write with `csrSel`=1 stores its data with bits [1:0] cleared. A read with `csrSel`=1 returns the saved PC.
- R8: A return (`mretTaken`) redirects to the saved PC as it stood in the cycle of the return.
- R9: When a trap and a return come in the same cycle, the trap wins. A trap also wins over a same-cycle CSR write to the saved PC. A trap uses the vector register value from before any write in that same cycle.
- R10: `redirectValid` is high exactly in the cycle after a trap or return strobe, and low otherwise. `redirectPc` is valid while `redirectValid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| csrWrEn | input | 1 | CSR write strobe |
| csrRdEn | input | 1 | CSR read strobe |
| csrSel | input | 1 | Register select: 0 = trap vector, 1 = saved PC |
| csrWrData | input | XLEN | CSR write data |
| csrRdData | output | XLEN | CSR readback value (same cycle) |
| trapTaken | input | 1 | Trap-taken strobe |
| trapIsIrq | input | 1 | 1 = interrupt, 0 = synchronous exception |
| trapCause | input | CAUSE_W | Cause number |
| trapPc | input | XLEN | PC of the trapping or interrupted instruction |
| mretTaken | input | 1 | Machine-mode return strobe |
| redirectValid | output | 1 | Redirect target valid |
| redirectPc | output | XLEN | Fetch redirect target |

## Verification
The bench builds the unit with its defaults: XLEN of 32, a cause field of 4 bits (16 table entries) and an 8-bit alignment of the base. With these values the table entries stop short of the alignment boundary, so the OR-based offset path is the variant under test. They also let cause 15 reach the last entry at offset 60, and let random bases exercise every base bit up to bit 31. Random data puts every mode value, including both reserved ones, into the vector register. Directed cycles combine a trap with a return and with a saved-PC write, to test the priority rules.

// File: rtl/tvec_pkg.sv
package tvec_pkg;

  typedef enum logic {
    SEL_VEC = 1'b0,
    SEL_EPC = 1'b1
  } csrSel_e;

  typedef struct packed {
    logic vecWr;
    logic epcWr;
    logic trapCap;
    logic mretLoad;
    logic redirLoad;
  } tvecStrobes_t;

endpackage

// File: rtl/tvec_ctrl.sv
module tvec_ctrl
  import tvec_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         csrWrEn,
  input  logic         csrSel,
  input  logic         trapTaken,
  input  logic         mretTaken,
  output tvecStrobes_t strb
);

  csrSel_e selDec;

  always_comb begin
    selDec         = csrSel_e'(csrSel);
    strb.vecWr     = csrWrEn && (selDec == SEL_VEC);
    // R9: trap capture of the saved PC outranks a software write
    strb.epcWr     = csrWrEn && (selDec == SEL_EPC) && !trapTaken;
    strb.trapCap   = trapTaken;
    // R9: trap outranks return
    strb.mretLoad  = mretTaken && !trapTaken;
    strb.redirLoad = trapTaken || mretTaken;
  end

  p_epc_guard_r9: assert property (@(posedge clk) disable iff (!rstN)
    (csrWrEn && csrSel && !trapTaken) |-> strb.epcWr);

endmodule

// File: rtl/tvec_datapath.sv
module tvec_datapath
  import tvec_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int CAUSE_W    = 4,
  parameter int ALIGN_BITS = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  tvecStrobes_t       strb,
  input  logic               csrRdEn,
  input  logic               csrSel,
  input  logic [XLEN-1:0]    csrWrData,
  input  logic               trapIsIrq,
  input  logic [CAUSE_W-1:0] trapCause,
  input  logic [XLEN-1:0]    trapPc,
  output logic [XLEN-1:0]    csrRdData,
  output logic               redirectValid,
  output logic [XLEN-1:0]    redirectPc
);

  localparam int BASE_W = XLEN - ALIGN_BITS;
  localparam int OFFS_W = CAUSE_W + 2;

  logic [BASE_W-1:0] baseQ;
  logic              vecModeQ;
  logic [XLEN-3:0]   epcQ;
  logic              redirValidQ;
  logic [XLEN-1:0]   redirPcQ;

  logic [XLEN-1:0] baseAddr;
  logic [XLEN-1:0] causeOffs;
  logic [XLEN-1:0] irqTarget;
  logic [XLEN-1:0] trapTarget;
  logic [XLEN-1:0] epcFull;
  logic [XLEN-1:0] vecReadVal;

  assign baseAddr   = {baseQ, {ALIGN_BITS{1'b0}}};
  assign causeOffs  = XLEN'(trapCause) << 2;
  assign epcFull    = {epcQ, 2'b00};
  assign vecReadVal = {baseQ, {(ALIGN_BITS-1){1'b0}}, vecModeQ};

  generate
    if (OFFS_W <= ALIGN_BITS) begin : g_orOffset
      assign irqTarget = baseAddr | causeOffs;
    end else begin : g_addOffset
      assign irqTarget = baseAddr + causeOffs;
    end
  endgenerate

  assign trapTarget = (trapIsIrq && vecModeQ) ? irqTarget : baseAddr;

  always_comb begin
    if (!csrRdEn)     csrRdData = '0;
    else if (csrSel)  csrRdData = epcFull;
    else              csrRdData = vecReadVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ    <= '0;
      vecModeQ <= 1'b0;
    end else if (strb.vecWr) begin
      baseQ <= csrWrData[XLEN-1:ALIGN_BITS];
      if (!csrWrData[1]) vecModeQ <= csrWrData[0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             epcQ <= '0;
    else if (strb.trapCap) epcQ <= trapPc[XLEN-1:2];
    else if (strb.epcWr)   epcQ <= csrWrData[XLEN-1:2];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      redirValidQ <= 1'b0;
      redirPcQ    <= '0;
    end else begin
      redirValidQ <= strb.redirLoad;
      if (strb.trapCap)       redirPcQ <= trapTarget;
      else if (strb.mretLoad) redirPcQ <= epcFull;
    end
  end

  assign redirectValid = redirValidQ;
  assign redirectPc    = redirPcQ;

  p_exc_base_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.trapCap && !trapIsIrq) |=> (redirectPc == $past(baseAddr)));

  p_irq_entry_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.trapCap && trapIsIrq && vecModeQ) |=>
      ((redirectPc - $past(baseAddr)) == ($past(causeOffs))));

  p_reserved_keep_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.vecWr && csrWrData[1]) |=> (vecModeQ == $past(vecModeQ)));

  p_capture_pc_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.trapCap |=> (epcQ == $past(trapPc[XLEN-1:2])));

  p_mret_target_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.mretLoad |=> (redirectPc == $past(epcFull)));

  p_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strb.redirLoad |=> !redirectValid);

endmodule

// File: rtl/trap_vector_unit.sv
module trap_vector_unit
  import tvec_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int CAUSE_W    = 4,
  parameter int ALIGN_BITS = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               csrWrEn,
  input  logic               csrRdEn,
  input  logic               csrSel,
  input  logic [XLEN-1:0]    csrWrData,
  output logic [XLEN-1:0]    csrRdData,
  input  logic               trapTaken,
  input  logic               trapIsIrq,
  input  logic [CAUSE_W-1:0] trapCause,
  input  logic [XLEN-1:0]    trapPc,
  input  logic               mretTaken,
  output logic               redirectValid,
  output logic [XLEN-1:0]    redirectPc
);

  tvecStrobes_t strb;

  tvec_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .csrWrEn   (csrWrEn),
    .csrSel    (csrSel),
    .trapTaken (trapTaken),
    .mretTaken (mretTaken),
    .strb      (strb)
  );

  tvec_datapath #(
    .XLEN       (XLEN),
    .CAUSE_W    (CAUSE_W),
    .ALIGN_BITS (ALIGN_BITS)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .csrRdEn       (csrRdEn),
    .csrSel        (csrSel),
    .csrWrData     (csrWrData),
    .trapIsIrq     (trapIsIrq),
    .trapCause     (trapCause),
    .trapPc        (trapPc),
    .csrRdData     (csrRdData),
    .redirectValid (redirectValid),
    .redirectPc    (redirectPc)
  );

endmodule

// File: tb/sim_trap_vector_unit.sv
module sim_trap_vector_unit;

  localparam int XLEN = 32;
  localparam int CW   = 4;
  localparam int AB   = 8;

  logic            clk = 1'b0;
  logic            rstN;
  logic            csrWrEn, csrRdEn, csrSel;
  logic [XLEN-1:0] csrWrData, csrRdData;
  logic            trapTaken, trapIsIrq, mretTaken;
  logic [CW-1:0]   trapCause;
  logic [XLEN-1:0] trapPc;
  logic            redirectValid;
  logic [XLEN-1:0] redirectPc;

  always #2 clk = ~clk;

  trap_vector_unit #(.XLEN(XLEN), .CAUSE_W(CW), .ALIGN_BITS(AB)) u0 (
    .clk(clk), .rstN(rstN), .csrWrEn(csrWrEn), .csrRdEn(csrRdEn),
    .csrSel(csrSel), .csrWrData(csrWrData), .csrRdData(csrRdData),
    .trapTaken(trapTaken), .trapIsIrq(trapIsIrq), .trapCause(trapCause),
    .trapPc(trapPc), .mretTaken(mretTaken),
    .redirectValid(redirectValid), .redirectPc(redirectPc)
  );

  int nCmp = 0;
  int nBad = 0;
  bit done = 0;

  logic [XLEN-1:0] mBase;
  logic            mVec;
  logic [XLEN-1:0] mEpc;

  function automatic logic [XLEN-1:0] expVecRead();
    return mBase | XLEN'(mVec);
  endfunction

  function automatic logic [XLEN-1:0] expTarget(logic isIrq, logic [CW-1:0] cause);
    if (isIrq && mVec) return mBase + (XLEN'(cause) * 4);
    return mBase;
  endfunction

  function automatic void modelVecWrite(logic [XLEN-1:0] d);
    mBase = d & ~((XLEN'(1) << AB) - 1);
    if (d[1] == 1'b0) mVec = d[0];
  endfunction

  task automatic chk(string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clearIn();
    csrWrEn = 0; csrRdEn = 0; csrSel = 0; csrWrData = '0;
    trapTaken = 0; trapIsIrq = 0; trapCause = '0; trapPc = '0; mretTaken = 0;
  endtask

  task automatic readReg(logic sel, string req);
    csrRdEn = 1; csrSel = sel;
    #1;
    chk(req, csrRdData, sel ? mEpc : expVecRead());
    csrRdEn = 0;
    #1;
    chk("R2 idle read", csrRdData, '0);
    @(negedge clk);
  endtask

  task automatic writeReg(logic sel, logic [XLEN-1:0] d);
    csrWrEn = 1; csrSel = sel; csrWrData = d;
    @(negedge clk);
    if (sel) mEpc = d & ~XLEN'(3);
    else     modelVecWrite(d);
    clearIn();
    chk("R10 no redirect after write", XLEN'(redirectValid), '0);
  endtask

  task automatic takeTrap(logic isIrq, logic [CW-1:0] cause, logic [XLEN-1:0] pc,
                          logic alsoMret, logic alsoEpcWr, logic [XLEN-1:0] wd);
    logic [XLEN-1:0] exp;
    string tag;
    exp = expTarget(isIrq, cause);
    tag = !isIrq ? "R4 exception target" : (mVec ? "R5 vectored irq target" : "R6 direct irq target");
    if (alsoMret || alsoEpcWr) tag = "R9 trap priority";
    trapTaken = 1; trapIsIrq = isIrq; trapCause = cause; trapPc = pc;
    mretTaken = alsoMret;
    csrWrEn = alsoEpcWr; csrSel = alsoEpcWr; csrWrData = wd;
    @(negedge clk);
    mEpc = pc & ~XLEN'(3);
    clearIn();
    chk(tag, redirectPc, exp);
    chk("R10 valid after trap", XLEN'(redirectValid), XLEN'(1));
    @(negedge clk);
    chk("R10 valid drops", XLEN'(redirectValid), '0);
  endtask

  task automatic doMret();
    logic [XLEN-1:0] exp;
    exp = mEpc;
    mretTaken = 1;
    @(negedge clk);
    clearIn();
    chk("R8 return target", redirectPc, exp);
    chk("R10 valid after return", XLEN'(redirectValid), XLEN'(1));
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    clearIn();
    rstN = 0;
    mBase = '0; mVec = 0; mEpc = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 reset valid", XLEN'(redirectValid), '0);
    readReg(0, "R1 reset vector");
    readReg(1, "R1 reset saved pc");

    // vectored mode request and readback
    writeReg(0, 32'h1000_0001);
    readReg(0, "R3 vectored readback");
    takeTrap(1, 4'd1, 32'h0000_0040, 0, 0, '0);
    takeTrap(0, 4'd2, 32'h0000_0044, 0, 0, '0);
    takeTrap(1, 4'd15, 32'h0000_0048, 0, 0, '0);
    chk("R5 cause 15 entry", mBase + 32'd60, 32'h1000_003C);
    // reserved modes keep vectored
    writeReg(0, 32'h2000_0002);
    readReg(0, "R3 reserved 2 keeps mode");
    writeReg(0, 32'h2100_0003);
    readReg(0, "R3 reserved 3 keeps mode");
    takeTrap(1, 4'd3, 32'h0000_0050, 0, 0, '0);
    // direct mode, low bits dropped
    writeReg(0, 32'h3000_00FC);
    readReg(0, "R2 low bits dropped");
    takeTrap(1, 4'd7, 32'h0000_1237, 0, 0, '0);
    readReg(1, "R7 captured pc");
    doMret();
    writeReg(1, 32'h0000_5557);
    readReg(1, "R7 written pc");
    doMret();
    // priority corners
    writeReg(0, 32'h4000_0001);
    takeTrap(1, 4'd5, 32'h0000_7777, 1, 0, '0);
    takeTrap(0, 4'd0, 32'h0000_8888, 0, 1, 32'h0000_9999);
    readReg(1, "R9 trap beats epc write");
    // trap uses pre-write vector value
    csrWrEn = 1; csrSel = 0; csrWrData = 32'h5000_0000;
    trapTaken = 1; trapIsIrq = 1; trapCause = 4'd2; trapPc = 32'h100;
    @(negedge clk);
    clearIn();
    chk("R9 trap uses old vector", redirectPc, 32'h4000_0008);
    mEpc = 32'h100; modelVecWrite(32'h5000_0000);
    readReg(0, "R9 write still lands");

    for (int i = 0; i < 400; i++) begin
      int op;
      op = int'($urandom_range(0, 4));
      case (op)
        0: writeReg(0, $urandom());
        1: writeReg(1, $urandom());
        2: takeTrap(1'($urandom_range(0, 1)), CW'($urandom()), $urandom(), 0, 0, '0);
        3: doMret();
        default: readReg(1'($urandom_range(0, 1)), "R2 random readback");
      endcase
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule